// File: doc/BRIEF.md
# Condition-field mask-logic unit

This unit holds eight 4-bit condition fields and executes five masked operations on them, chosen by a 32-bit instruction word. The operations are: reduce one field to a single bit of an integer result, broadcast the low bit of an integer operand into a field, combine a field into another field, reduce a field into one chosen bit of any field, and move a field with masking and per-bit inversion. Each operation tests every bit of a field against a 4-bit mode pattern. A bit counts as a hit when its mask bit is set and the field bit equals the mode bit.

A single flag in the instruction has two meanings. For the reductions it picks OR (flag set) or AND (flag clear). For the field-writing operations it picks read-modify-write (flag set), where masked-out destination bits are kept, or overwrite (flag clear). The integer register file sits outside the block. The unit drives a read address, takes the read data back on the same cycle, and issues a registered write one cycle after the instruction is accepted. Condition fields are updated on that same edge, so an instruction issued on the next cycle sees the new values.

Top module: `crf_masklogic`

## Requirements
- R1: During and after reset every condition field is zero, `int_wr_en` and `illegal` are low, and `insn_ready` is low during reset and high from the first clock edge after reset is released.
- R2: With select 00 (instruction bits 12:11), the hit vector is h = mask & ~(mode ^ src). Here src is the field chosen by bits 15:13, mask is bits 19:16, mode is bits 4:1 and the flag is bit 20. The result bit is OR(h) when the flag is 1 and AND(h) when it is 0. It is written to bit 0 of `int_wr_data`, with all other bits zero, at the address in bits 25:21. No field changes.
- R3: With select 01, every bit of the field addressed by bits 15:13 is computed as mask & ~(mode ^ b). Here b is bit 0 of `int_rd_data`, except that b is 0 whenever the register number in bits 25:21 is zero. `int_rd_addr` always shows bits 25:21.
- R4: In the field-writing operations (select 01, and select 11 with either value of bit 0), a flag of 1 keeps the old destination bits wherever mask is 0. A flag of 0 replaces the whole field.
- R5: With select 11 and bit 0 clear, the field addressed by bits 25:23 receives h, computed from the field addressed by bits 15:13, merged as described in R4.
- R6: With select 11 and bit 0 set, the destination (bits 25:23) receives ((mask & src) | kept old bits) ^ mode. A bit set in both mask and mode therefore copies the source bit inverted, and a bit with mask 0, mode 1 and flag 0 becomes 1.
- R7: With select 10, bits 23:21 select the destination field and bits 25:24 give the bit number k inside it. Bit k receives the OR or AND reduction of h, and no other field bit changes.
- R8: An instruction whose bits 31:26 differ from 19, or whose bit 5 is set, raises `illegal` for one cycle. It writes neither a field nor an integer register.
- R9: An instruction takes effect only on a clock edge where `insn_valid` and `insn_ready` are both high. Its field update and its integer write appear right after that edge, and not before.
- R10: `cr_flat[31-4f -: 4]` shows field f. Bit k of a field (k=0 first, most significant) is nibble bit 3-k, and it pairs with mask and mode nibble bit 3-k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction present |
| insn_ready | output | 1 | Unit can accept an instruction |
| insn | input | 32 | Instruction word |
| int_rd_addr | output | 5 | Integer source register number |
| int_rd_data | input | XLEN | Integer source value for that register |
| int_wr_en | output | 1 | Integer write strobe |
| int_wr_addr | output | 5 | Integer destination register number |
| int_wr_data | output | XLEN | Integer write value |
| illegal | output | 1 | Rejected-instruction pulse |
| cr_flat | output | 32 | All eight condition fields |

## Verification
The assertions check properties that hold on every cycle. An integer write always carries zeros above bit 0 and never coincides with a field change. A rejected instruction leaves every field untouched. An idle cycle produces no write. A single-bit operation flips at most one field bit. Only the bench scenarios can show the actual arithmetic: the OR/AND choice, the merge of kept bits, the inversion by the mode bits, the zero substituted for register 0, and the exact field and bit positions.

// File: rtl/crf_masklogic.sv
module crf_masklogic #(
  parameter int XLEN   = 64,
  parameter int OPCODE = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  logic [31:0]     insn,
  output logic [4:0]      int_rd_addr,
  input  logic [XLEN-1:0] int_rd_data,
  output logic            int_wr_en,
  output logic [4:0]      int_wr_addr,
  output logic [XLEN-1:0] int_wr_data,
  output logic            illegal,
  output logic [31:0]     cr_flat
);
  localparam int NFLD = 8;

  logic [3:0] fld [NFLD];
  logic       rdy_q, bitop_q;

  logic [5:0] op;
  logic [4:0] f6;
  logic       flag, zbit, rc;
  logic [3:0] mask, mode, src, hit_src, hit_int, fval, keep;
  logic [2:0] fa, fidx;
  logic [1:0] sel, bpos;
  logic       bad, b_lsb, red, fw, iw, accept;
  logic       unused_bits;

  assign op   = insn[31:26];
  assign f6   = insn[25:21];
  assign flag = insn[20];
  assign mask = insn[19:16];
  assign fa   = insn[15:13];
  assign sel  = insn[12:11];
  assign zbit = insn[5];
  assign mode = insn[4:1];
  assign rc   = insn[0];
  assign unused_bits = ^{insn[10:6], int_rd_data[XLEN-1:1]};

  assign int_rd_addr = f6;
  assign insn_ready  = rdy_q;
  assign accept      = insn_valid & rdy_q;
  assign bad         = (op != OPCODE[5:0]) | zbit;

  assign src     = fld[fa];
  assign b_lsb   = (f6 != 5'd0) & int_rd_data[0];
  assign hit_src = mask & ~(mode ^ src);
  assign hit_int = mask & ~(mode ^ {4{b_lsb}});
  assign red     = flag ? |hit_src : &hit_src;
  assign bpos    = 2'd3 - f6[4:3];

  always_comb begin
    fw   = 1'b0;
    iw   = 1'b0;
    fidx = f6[4:2];
    keep = flag ? (fld[f6[4:2]] & ~mask) : 4'b0000;
    fval = 4'b0000;
    case (sel)
      2'b00: iw = 1'b1;
      2'b01: begin
        fw   = 1'b1;
        fidx = fa;
        fval = hit_int | (flag ? (fld[fa] & ~mask) : 4'b0000);
      end
      2'b10: begin
        fw   = 1'b1;
        fidx = f6[2:0];
        fval = fld[f6[2:0]];
        fval[bpos] = red;
      end
      default: begin
        fw   = 1'b1;
        fval = rc ? (((mask & src) | keep) ^ mode) : (hit_src | keep);
      end
    endcase
    if (bad) begin
      fw = 1'b0;
      iw = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q       <= 1'b0;
      bitop_q     <= 1'b0;
      int_wr_en   <= 1'b0;
      int_wr_addr <= 5'd0;
      int_wr_data <= '0;
      illegal     <= 1'b0;
      for (int i = 0; i < NFLD; i++) fld[i] <= 4'b0000;
    end else begin
      rdy_q     <= 1'b1;
      int_wr_en <= accept & iw;
      illegal   <= accept & bad;
      bitop_q   <= accept & ~bad & (sel == 2'b10);
      if (accept & iw) begin
        int_wr_addr <= f6;
        int_wr_data <= {{(XLEN-1){1'b0}}, red};
      end
      if (accept & fw) fld[fidx] <= fval;
    end
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_flat
    assign cr_flat[31-4*g -: 4] = fld[g];
  end

  AST_INT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    int_wr_en |-> (int_wr_data[XLEN-1:1] == '0));  // R2
  AST_INT_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    int_wr_en |-> (cr_flat == $past(cr_flat)));  // R2
  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!int_wr_en && cr_flat == $past(cr_flat)));  // R8
  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(insn_valid && insn_ready) |=> (!int_wr_en && !illegal && $stable(cr_flat)));  // R9
  AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bitop_q |-> ($countones(cr_flat ^ $past(cr_flat)) <= 1));  // R7
endmodule

// File: tb/sim_crf_masklogic.sv
module sim_crf_masklogic;
  logic        clk = 1'b0, rst_n = 1'b0, insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] int_rd_data = '0;
  logic        insn_ready, int_wr_en, illegal;
  logic [4:0]  int_rd_addr, int_wr_addr;
  logic [63:0] int_wr_data;
  logic [31:0] cr_flat;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  crf_masklogic u0 (.clk, .rst_n, .insn_valid, .insn_ready, .insn, .int_rd_addr,
    .int_rd_data, .int_wr_en, .int_wr_addr, .int_wr_data, .illegal, .cr_flat);

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] f6, logic m,
      logic [3:0] mask, logic [2:0] fa, logic [1:0] sel, logic z, logic [3:0] mode, logic b0);
    return {op, f6, m, mask, fa, sel, 5'd0, z, mode, b0};
  endfunction

  typedef struct packed {
    logic [31:0] insn; logic [63:0] rd; logic [31:0] cr;
    logic wen; logic [4:0] wa; logic wd; logic ill; logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{mk(19,0,0,4'b1111,2,2'b01,0,4'b0101,0), 64'h0, 32'h00A00000, 0,0,0,0, 4'd3},  // R3 R10 field 2 <- 1010
    '{mk(19,3,0,4'b1100,5,2'b01,0,4'b1010,0), 64'h1, 32'h00A00800, 0,0,0,0, 4'd3},  // R3 lsb 1
    '{mk(19,4,1,4'b0011,5,2'b01,0,4'b0000,0), 64'hFFFFFFFFFFFFFFFE, 32'h00A00B00, 0,0,0,0, 4'd4}, // R4
    '{mk(19,7,1,4'b0110,2,2'b00,0,4'b0000,0), 64'h0, 32'h00A00B00, 1,7,1,0, 4'd2},  // R2 OR
    '{mk(19,7,0,4'b1111,2,2'b00,0,4'b1010,0), 64'h0, 32'h00A00B00, 1,7,1,0, 4'd2},  // R2 AND true
    '{mk(19,8,0,4'b1111,2,2'b00,0,4'b1011,0), 64'h0, 32'h00A00B00, 1,8,0,0, 4'd2},  // R2 AND false
    '{mk(19,5'b00100,0,4'b1111,5,2'b11,0,4'b0000,0), 64'h0, 32'h04A00B00, 0,0,0,0, 4'd5}, // R5
    '{mk(19,5'b01000,1,4'b0001,5,2'b11,0,4'b0001,0), 64'h0, 32'h04B00B00, 0,0,0,0, 4'd4}, // R4 R5
    '{mk(19,5'b01100,0,4'b1100,2,2'b11,0,4'b0100,1), 64'h0, 32'h04BC0B00, 0,0,0,0, 4'd6}, // R6
    '{mk(19,5'b01100,1,4'b0011,1,2'b11,0,4'b0010,1), 64'h0, 32'h04BE0B00, 0,0,0,0, 4'd6}, // R6 R4
    '{mk(19,5'b01110,1,4'b1000,2,2'b10,0,4'b1000,0), 64'h0, 32'h04BE0B40, 0,0,0,0, 4'd7}, // R7 bit1
    '{mk(19,5'b11110,0,4'b1111,2,2'b10,0,4'b1011,0), 64'h0, 32'h04BE0B50, 0,0,0,0, 4'd7}, // R7 bit3
    '{mk(19,5'b01110,1,4'b0000,2,2'b10,0,4'b0000,0), 64'h0, 32'h04BE0B10, 0,0,0,0, 4'd7}, // R7 clear
    '{mk(18,0,0,4'b1111,7,2'b01,0,4'b0000,0), 64'h0, 32'h04BE0B10, 0,0,0,1, 4'd8},  // R8 opcode
    '{mk(19,9,1,4'b1111,2,2'b00,1,4'b0000,0), 64'h0, 32'h04BE0B10, 0,0,0,1, 4'd8},  // R8 bit 5
    '{mk(19,0,0,4'b1111,0,2'b01,0,4'b0000,0), 64'hFFFFFFFFFFFFFFFF, 32'hF4BE0B10, 0,0,0,0, 4'd3} // R3 reg 0
  };

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] i, logic [63:0] rd);
    @(negedge clk);
    insn = i; int_rd_data = rd; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cr_flat == 0 && !int_wr_en && !illegal && !insn_ready, "R1", "in reset",
          {cr_flat, int_wr_en, illegal, insn_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(insn_ready && cr_flat == 0 && !int_wr_en, "R1", "after reset",
          {cr_flat, insn_ready}, 1);

    for (int v = 0; v < 16; v++) begin
      issue(VECS[v].insn, VECS[v].rd);
      check(cr_flat == VECS[v].cr && int_wr_en == VECS[v].wen && illegal == VECS[v].ill &&
            (!VECS[v].wen || (int_wr_addr == VECS[v].wa && int_wr_data == {63'd0, VECS[v].wd})),
            $sformatf("R%0d", VECS[v].req), $sformatf("vector %0d", v),
            {cr_flat, int_wr_en, illegal, int_wr_addr, int_wr_data[0]},
            {VECS[v].cr, VECS[v].wen, VECS[v].ill, VECS[v].wa, VECS[v].wd});
    end

    // R3: read address follows bits 25:21
    @(negedge clk);
    insn = mk(19, 13, 0, 4'b1111, 4, 2'b01, 0, 4'b0000, 0);
    #1 check(int_rd_addr == 13, "R3", "rd addr", int_rd_addr, 13);

    // R9: no effect without valid
    @(negedge clk);
    check(cr_flat == 32'hF4BE0B10 && !int_wr_en, "R9", "idle", cr_flat, 32'hF4BE0B10);

    // R9: effect only after the accepting edge
    @(negedge clk);
    insn = mk(19, 0, 0, 4'b1111, 7, 2'b01, 0, 4'b0000, 0); int_rd_data = 0; insn_valid = 1'b1;
    #1 check(cr_flat == 32'hF4BE0B10, "R9", "before edge", cr_flat, 32'hF4BE0B10);
    @(negedge clk);
    insn_valid = 1'b0;
    check(cr_flat == 32'hF4BE0B1F, "R9", "after edge", cr_flat, 32'hF4BE0B1F);

    // R6: mask 0, mode 1, overwrite sets the bit
    issue(mk(19, 5'b00000, 0, 4'b0000, 7, 2'b11, 0, 4'b0001, 1), 0);
    check(cr_flat == 32'h14BE0B1F, "R6", "set by mode", cr_flat, 32'h14BE0B1F);

    // R1: reset mid-run clears fields
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cr_flat == 0 && insn_ready && !int_wr_en, "R1", "re-reset", cr_flat, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule